// File: doc/BRIEF.md
# Read-Masked Temperature Result Register

This block keeps the most recent digital temperature sample so that a host can read it over a serial bus. Each finished conversion arrives as a one-cycle valid strobe carrying a 12-bit two's complement sample. The block trims the sample to the resolution currently selected (9, 10, 11 or 12 bits) and places it at the top of a 16-bit word. Every bit below the active resolution reads as zero, and bit 15 holds the sign.

Two copies of each trimmed sample are kept. The evaluation copy loads on every conversion and feeds the alarm comparators. The readable copy loads only when the bus interface reports that no read is in progress. A sample that arrives during a read is dropped from the readable copy and is never applied later. The sample input has no back-pressure: a conversion strobe is always accepted in its cycle, and the read flag only decides which copies load.

Top module: `temp_result_reg`

## Requirements
- R1: After reset, both `rd_value` and `eval_value` are all zeros.
- R2: Sample bit 11 (the sign) appears at output bit 15, and sample bits 10..0 appear at output bits 14..4, subject to R3.
- R3: `res_sel` sets the number of data bits kept: 00 keeps 9, 01 keeps 10, 10 keeps 11 and 11 keeps 12. Output bits below the kept field are zero. With 9 bits, bits 6..0 are zero; with 12 bits, bits 3..0 are zero.
- R4: When `conv_valid` is high at a clock edge, `eval_value` holds the trimmed sample after that edge, whatever the state of `rd_busy`.
- R5: When `conv_valid` and `rd_busy` are both high at the same edge, `rd_value` keeps its previous value.
- R6: When `conv_valid` is high and `rd_busy` is low at an edge, `rd_value` takes the trimmed sample after that edge.
- R7: A skipped sample is not applied later. With no `conv_valid`, both outputs hold their values, including when `rd_busy` falls.
- R8: A change of `res_sel` leaves stored values as they are. It affects only samples that arrive later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe marking a finished conversion |
| conv_sample | input | 12 | Signed sample, full 12-bit precision |
| res_sel | input | 2 | Resolution select (see R3) |
| rd_busy | input | 1 | High while a bus read of the register is in progress |
| rd_value | output | 16 | Readable, left-justified temperature |
| eval_value | output | 16 | Unmasked copy for the alarm comparators |

## Verification
On every cycle, the assertions check that both outputs hold their value when no strobe arrives and that the readable copy holds during a busy read. They also check that a load with no read in progress leaves the two copies equal, and that zero-filled low bits match the resolution in force when the copy was loaded. Only the bench's scenarios can show that the bit placement is exact for each resolution code, and that a sample skipped during a read never shows up later. They also cover a resolution change with no strobe leaving stored values untouched.

// File: rtl/temp_result_pkg.sv
package temp_result_pkg;
  localparam int SAMPLE_W = 12;
  localparam int WORD_W   = 16;
  localparam int MIN_BITS = 9;

  typedef enum logic [1:0] {
    RES_9  = 2'b00,
    RES_10 = 2'b01,
    RES_11 = 2'b10,
    RES_12 = 2'b11
  } res_t;
endpackage

// File: rtl/temp_trunc.sv
module temp_trunc
  import temp_result_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int WW = WORD_W
) (
  input  logic [SW-1:0] sample,
  input  logic [1:0]    res,
  output logic [WW-1:0] word
);
  localparam int PAD = WW - SW;

  logic [SW-1:0] keep_mask;

  // Mask keeps the top MIN_BITS+res bits of the sample.
  always_comb begin
    for (int i = 0; i < SW; i++) begin
      keep_mask[i] = (i >= (SW - MIN_BITS - int'(res)));
    end
  end

  assign word = {sample & keep_mask, {PAD{1'b0}}};
endmodule

// File: rtl/temp_hold_reg.sv
module temp_hold_reg #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] d,
  output logic [WW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R7
endmodule

// File: rtl/temp_result_reg.sv
module temp_result_reg
  import temp_result_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_valid,
  input  logic [SAMPLE_W-1:0] conv_sample,
  input  logic [1:0]          res_sel,
  input  logic                rd_busy,
  output logic [WORD_W-1:0]   rd_value,
  output logic [WORD_W-1:0]   eval_value
);
  localparam int LOW_ZERO_9 = WORD_W - MIN_BITS;

  logic [WORD_W-1:0] trimmed;
  logic              rd_load;
  logic [1:0]        rd_res;

  temp_trunc #(.SW(SAMPLE_W), .WW(WORD_W)) u_trunc (
    .sample (conv_sample),
    .res    (res_sel),
    .word   (trimmed)
  );

  assign rd_load = conv_valid && !rd_busy;

  temp_hold_reg #(.WW(WORD_W)) u_eval (
    .clk (clk), .rst_n (rst_n), .load (conv_valid), .d (trimmed), .q (eval_value)
  );

  temp_hold_reg #(.WW(WORD_W)) u_read (
    .clk (clk), .rst_n (rst_n), .load (rd_load), .d (trimmed), .q (rd_value)
  );

  // Resolution that was in force when the readable copy last loaded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_res <= 2'b00;
    else if (rd_load) rd_res <= res_sel;
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && rd_busy) |=> $stable(rd_value)); // R5
  AST_FREE_LOAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !rd_busy) |=> (rd_value == eval_value)); // R6
  AST_EVAL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> (eval_value[WORD_W-1] == $past(conv_sample[SAMPLE_W-1]))); // R4
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_value[WORD_W-SAMPLE_W-1:0] == '0) &&
    ((rd_res != 2'b00) || (rd_value[LOW_ZERO_9-1:0] == '0))); // R3
endmodule

// File: tb/tb_temp_result_reg.sv
module tb_temp_result_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_valid = 1'b0;
  logic [11:0] conv_sample = '0;
  logic [1:0]  res_sel = 2'b00;
  logic        rd_busy = 1'b0;
  logic [15:0] rd_value, eval_value;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  temp_result_reg dut (.*);

  // {sample, res, busy}
  localparam int NV = 8;
  localparam logic [14:0] VEC [NV] = '{
    {12'h7FF, 2'b11, 1'b0},
    {12'h7FF, 2'b00, 1'b0},
    {12'h7FF, 2'b01, 1'b0},
    {12'h7FF, 2'b10, 1'b0},
    {12'h801, 2'b11, 1'b0},
    {12'hFFF, 2'b00, 1'b0},
    {12'h123, 2'b10, 1'b1},
    {12'hABC, 2'b01, 1'b0}
  };

  function automatic logic [15:0] trim(input logic [11:0] s, input logic [1:0] r);
    logic [15:0] w;
    int keep;
    w = {s, 4'h0};
    keep = 9 + int'(r);
    for (int i = 0; i < 16; i++) if (i < 16 - keep) w[i] = 1'b0;
    return w;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [11:0] s, input logic [1:0] r, input logic b);
    @(negedge clk);
    conv_sample = s; res_sel = r; rd_busy = b; conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] exp_rd;
    repeat (3) @(negedge clk);
    chk("R1 rd", rd_value, 16'h0);
    chk("R1 eval", eval_value, 16'h0);
    rst_n = 1'b1;
    exp_rd = '0;
    for (int k = 0; k < NV; k++) begin
      conv(VEC[k][14:3], VEC[k][2:1], VEC[k][0]);
      if (!VEC[k][0]) exp_rd = trim(VEC[k][14:3], VEC[k][2:1]);
      chk("R2 R3 R4 eval", eval_value, trim(VEC[k][14:3], VEC[k][2:1]));
      chk("R5 R6 rd", rd_value, exp_rd);
    end
    // Directed values per resolution for R3
    conv(12'h7FF, 2'b00, 1'b0); chk("R3 9b", rd_value, 16'h7F80);
    conv(12'h7FF, 2'b11, 1'b0); chk("R3 12b", rd_value, 16'h7FF0);
    conv(12'h801, 2'b11, 1'b0); chk("R2 sign", rd_value, 16'h8010);
    // R5 / R7: skipped sample never appears
    conv(12'h555, 2'b11, 1'b1);
    chk("R5 hold", rd_value, 16'h8010);
    chk("R4 eval busy", eval_value, 16'h5550);
    @(negedge clk); rd_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 no late apply", rd_value, 16'h8010);
    chk("R7 eval stable", eval_value, 16'h5550);
    // R8: resolution change does not re-trim
    res_sel = 2'b00;
    repeat (2) @(negedge clk);
    chk("R8 rd", rd_value, 16'h8010);
    chk("R8 eval", eval_value, 16'h5550);
    conv(12'h555, 2'b00, 1'b0);
    chk("R8 later sample", rd_value, 16'h5500);
    // R1: reset clears again
    rst_n = 1'b0; @(negedge clk);
    chk("R1 reset rd", rd_value, 16'h0);
    chk("R1 reset eval", eval_value, 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule